// File: doc/BRIEF.md
# Event Fragment Framer

This block turns a stream of 64-bit payload words into a self-describing event fragment. A start strobe brings in the identifying fields of an event: trigger number, bunch number, source id and event type. The block then emits one header word and passes the payload words through in order. After the last payload word it emits one trailer word. The trailer carries the fragment size in 64-bit words, a status byte and a 16-bit CRC that is built on the fly as the words leave.

The output is a valid/ready stream with an end-of-fragment flag. The payload input is a valid/ready stream with a last flag. Payload words flow straight through, combinationally, so a stall at the output holds the upstream source directly and the running count and CRC advance only on accepted words. A new start strobe is honoured only when no fragment is in progress.

Top module: `frag_framer`

## Requirements
- R1: While reset is asserted and after it is released with no start strobe, `out_valid_o` and `pl_ready_o` are both 0.
- R2: In the cycle after an accepted start strobe, the block offers a header word laid out as 4'h5 in [63:60], format version in [59:56], trigger number in [55:32], bunch number in [31:20], source id in [19:8], event type in [7:4] and zeros in [3:0]. The header holds until it is accepted.
- R3: After the header, every payload word accepted at the input appears unchanged on the output in the same cycle, in the same order, up to and including the word flagged last.
- R4: In the cycle after the last payload word is accepted, the block offers a trailer word with 4'hA in [63:60] and the length in [55:32]. The length counts the header, payload and trailer words together. All other bits are zero except the status and CRC fields.
- R5: The trailer CRC in [15:0] is CRC-16 with polynomial 0x1021 and initial value 0xFFFF, without reflection. It is computed bit-serially, most significant bit first, over the header, all payload words and the trailer word with its CRC field taken as zero.
- R6: The trailer status field [31:24] is the value on `status_i` in the cycle the last payload word is accepted. Later changes of `status_i` do not affect it.
- R7: `out_eof_o` is 1 on the trailer word and 0 on header and payload words.
- R8: A start strobe that arrives while a fragment is in progress has no effect on the current fragment and does not open a new one.
- R9: `pl_ready_o` is never 1 while `out_ready_i` is 0. A header or trailer word that is offered and not accepted stays valid and unchanged in the next cycle. Stalls change neither the length nor the CRC.
- R10: After the trailer is accepted, `out_valid_o` stays 0 until the next start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Opens a fragment when idle |
| trig_i | input | 24 | Trigger number for the header |
| bunch_i | input | 12 | Bunch number for the header |
| src_i | input | 12 | Source id for the header |
| evtype_i | input | 4 | Event type for the header |
| pl_valid_i | input | 1 | Payload word valid |
| pl_data_i | input | 64 | Payload word |
| pl_last_i | input | 1 | Marks the final payload word |
| pl_ready_o | output | 1 | Payload word accepted when high with valid |
| status_i | input | 8 | Status byte, sampled with the last payload word |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | 64 | Output word |
| out_eof_o | output | 1 | Output word is the trailer |
| out_ready_i | input | 1 | Downstream accepts the output word |

## Verification
The header is due one clock after the start strobe, and the bench checks `out_valid_o` at that exact cycle. Payload words are due in the same cycle they are accepted, because the path is combinational. The trailer is due one clock after the last payload handshake. The bench drives all inputs on the falling edge and samples each output handshake a little after it, so every comparison sees the settled word of that cycle. Each handshake is compared against a queue of words that the bench has computed arithmetically. The sweep covers payload lengths 1 to 6 under three backpressure patterns, with upstream gaps and stray start strobes mixed in, and the status input is corrupted after the last word to show that it was captured.

// File: rtl/frag_framer.sv
module frag_framer #(
  parameter logic [3:0] FMT_VERSION = 4'h1,
  parameter logic [3:0] HDR_MARK    = 4'h5,
  parameter logic [3:0] TRL_MARK    = 4'hA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [23:0] trig_i,
  input  logic [11:0] bunch_i,
  input  logic [11:0] src_i,
  input  logic [3:0]  evtype_i,
  input  logic        pl_valid_i,
  input  logic [63:0] pl_data_i,
  input  logic        pl_last_i,
  output logic        pl_ready_o,
  input  logic [7:0]  status_i,
  output logic        out_valid_o,
  output logic [63:0] out_data_o,
  output logic        out_eof_o,
  input  logic        out_ready_i
);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_BODY, S_TRL} st_t;

  st_t         state;
  logic [63:0] hdr_q;
  logic [23:0] cnt;
  logic [15:0] crc;
  logic [7:0]  stat_q;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [63:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 63; i >= 0; i--)
      r = {r[14:0], 1'b0} ^ ((r[15] ^ d[i]) ? 16'h1021 : 16'h0000);
    return r;
  endfunction

  logic [63:0] trl_base;
  logic [15:0] trl_crc;
  logic        fire;
  logic [15:0] crc_next;

  assign trl_base = {TRL_MARK, 4'h0, cnt + 24'd1, stat_q, 24'h0};
  assign trl_crc  = crc_step(crc, trl_base);

  always_comb begin
    out_valid_o = 1'b0;
    out_data_o  = 64'h0;
    out_eof_o   = 1'b0;
    pl_ready_o  = 1'b0;
    case (state)
      S_HDR: begin
        out_valid_o = 1'b1;
        out_data_o  = hdr_q;
      end
      S_BODY: begin
        out_valid_o = pl_valid_i;
        out_data_o  = pl_data_i;
        pl_ready_o  = out_ready_i;
      end
      S_TRL: begin
        out_valid_o = 1'b1;
        out_data_o  = {trl_base[63:16], trl_crc};
        out_eof_o   = 1'b1;
      end
      default: ;
    endcase
  end

  assign fire     = out_valid_o & out_ready_i;
  assign crc_next = crc_step(crc, out_data_o);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      hdr_q  <= 64'h0;
      cnt    <= 24'h0;
      crc    <= 16'hFFFF;
      stat_q <= 8'h0;
    end else begin
      case (state)
        S_IDLE: if (start_i) begin
          hdr_q <= {HDR_MARK, FMT_VERSION, trig_i, bunch_i, src_i, evtype_i, 4'h0};
          cnt   <= 24'h0;
          crc   <= 16'hFFFF;
          state <= S_HDR;
        end
        S_HDR: if (fire) begin
          cnt   <= cnt + 24'd1;
          crc   <= crc_next;
          state <= S_BODY;
        end
        S_BODY: if (fire) begin
          cnt <= cnt + 24'd1;
          crc <= crc_next;
          if (pl_last_i) begin
            stat_q <= status_i;
            state  <= S_TRL;
          end
        end
        S_TRL: if (fire) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9: upstream is never told to advance while downstream stalls
  a_r9_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
    pl_ready_o |-> out_ready_i);

  // R9: a stalled header or trailer is held unchanged
  a_r9_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i && state != S_BODY) |=> (out_valid_o && $stable(out_data_o)));

  // R10: nothing is offered right after the trailer leaves
  a_r10_idle_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_ready_i && out_eof_o) |=> !out_valid_o);

  // R8: a strobe during the payload phase does not restart the header
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BODY && start_i && !(fire && pl_last_i)) |=> (state == S_BODY));

  // R4: the trailer always counts at least header and trailer
  a_r4_min_length: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_eof_o) |-> (out_data_o[63:60] == TRL_MARK && out_data_o[55:32] >= 24'd3));

  // R2: a header follows an idle strobe one cycle later
  a_r2_header_next: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && start_i) |=> (out_valid_o && !out_eof_o && out_data_o[63:60] == HDR_MARK));

endmodule

// File: tb/frag_framer_bench.sv
module frag_framer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] trig_i = '0;
  logic [11:0] bunch_i = '0;
  logic [11:0] src_i = '0;
  logic [3:0]  evtype_i = '0;
  logic        pl_valid_i = 1'b0;
  logic [63:0] pl_data_i = '0;
  logic        pl_last_i = 1'b0;
  logic        pl_ready_o;
  logic [7:0]  status_i = '0;
  logic        out_valid_o;
  logic [63:0] out_data_o;
  logic        out_eof_o;
  logic        out_ready_i = 1'b0;

  frag_framer u_frag_framer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .trig_i(trig_i),
    .bunch_i(bunch_i), .src_i(src_i), .evtype_i(evtype_i),
    .pl_valid_i(pl_valid_i), .pl_data_i(pl_data_i), .pl_last_i(pl_last_i),
    .pl_ready_o(pl_ready_o), .status_i(status_i), .out_valid_o(out_valid_o),
    .out_data_o(out_data_o), .out_eof_o(out_eof_o), .out_ready_i(out_ready_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [63:0] exp_q[$];
  int          kind_q[$];

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [63:0] w);
    logic [15:0] r;
    r = c;
    for (int b = 7; b >= 0; b--) begin
      r = r ^ {w[8*b +: 8], 8'h00};
      for (int k = 0; k < 8; k++)
        r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    end
    return r;
  endfunction

  function automatic bit rdy_pat(input int cyc, input int mode);
    if (mode == 0) return 1'b1;
    if (mode == 1) return (cyc % 3) != 2;
    return (cyc % 5) < 2;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // monitor: every output handshake is compared against the expected queue
  always @(negedge clk) begin
    #2;
    if (rst_n && out_valid_o && out_ready_i) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8/R10 stray word", out_data_o, 64'h0);
      end else begin
        logic [63:0] e;
        int kd;
        e  = exp_q.pop_front();
        kd = kind_q.pop_front();
        if (kd == 0) check(out_data_o == e, "R2 header", out_data_o, e);
        else if (kd == 1) check(out_data_o == e, "R3 payload", out_data_o, e);
        else begin
          check(out_data_o[63:32] == e[63:32], "R4 trailer length", out_data_o, e);
          check(out_data_o[31:24] == e[31:24], "R6 trailer status", out_data_o, e);
          check(out_data_o[15:0] == e[15:0] && out_data_o[23:16] == 8'h0, "R5 trailer crc", out_data_o, e);
        end
        check(out_eof_o == (kd == 2), "R7 eof flag", {63'h0, out_eof_o}, {63'h0, kd == 2});
      end
    end
  end

  task automatic run_frag(input logic [23:0] trig, input logic [11:0] bx, input logic [11:0] src,
                          input logic [3:0] ty, input logic [7:0] st, input int n,
                          input int mode, input bit glitch);
    logic [63:0] w;
    logic [63:0] pw[8];
    logic [15:0] c;
    int k;
    int cyc;
    w = {4'h5, 4'h1, trig, bx, src, ty, 4'h0};
    c = ref_crc(16'hFFFF, w);
    exp_q.push_back(w); kind_q.push_back(0);
    for (int i = 0; i < n; i++) begin
      pw[i] = {trig[15:0] ^ 16'h3C3C, 8'(i), ~trig[7:0], 32'h9E37_79B9 * (i + 1)};
      c = ref_crc(c, pw[i]);
      exp_q.push_back(pw[i]); kind_q.push_back(1);
    end
    w = {4'hA, 4'h0, 24'(n + 2), st, 24'h0};
    c = ref_crc(c, w);
    exp_q.push_back(w | {48'h0, c}); kind_q.push_back(2);

    @(negedge clk);
    start_i = 1'b1; trig_i = trig; bunch_i = bx; src_i = src; evtype_i = ty;
    status_i = st; out_ready_i = rdy_pat(0, mode);
    @(negedge clk);
    start_i = 1'b0; trig_i = ~trig; bunch_i = ~bx; src_i = ~src; evtype_i = ~ty;
    #1;
    check(out_valid_o == 1'b1, "R2 header due one cycle after start", {63'h0, out_valid_o}, 64'h1);
    k = 0; cyc = 0;
    out_ready_i = rdy_pat(cyc, mode);
    pl_valid_i = 1'b1; pl_data_i = pw[0]; pl_last_i = (n == 1);
    #0;
    while (k < n) begin
      if (cyc > 0) begin
        @(negedge clk);
        out_ready_i = rdy_pat(cyc, mode);
        pl_valid_i = !(mode != 0 && (cyc % 4) == 1);
        pl_data_i = pw[k]; pl_last_i = (k == n - 1);
        start_i = glitch && (cyc == 2);
        trig_i = 24'hFFFFFF;
        #1;
      end
      check(!(pl_ready_o && !out_ready_i), "R9 ready follows out_ready", {63'h0, pl_ready_o}, 64'h0);
      if (pl_valid_i && pl_ready_o) k++;
      cyc++;
    end
    while (exp_q.size() != 0) begin
      @(negedge clk);
      start_i = 1'b0; pl_valid_i = 1'b0; pl_last_i = 1'b0; status_i = ~st;
      out_ready_i = rdy_pat(cyc, mode);
      cyc++;
      #3;
    end
    repeat (3) begin
      @(negedge clk);
      out_ready_i = 1'b1;
      #1;
      check(out_valid_o == 1'b0, "R10 idle after trailer", {63'h0, out_valid_o}, 64'h0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(1'b0, "watchdog expired", 64'h0, 64'h1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(out_valid_o == 1'b0 && pl_ready_o == 1'b0, "R1 in reset", {62'h0, out_valid_o, pl_ready_o}, 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    check(out_valid_o == 1'b0 && pl_ready_o == 1'b0, "R1 after reset", {62'h0, out_valid_o, pl_ready_o}, 64'h0);

    for (int mode = 0; mode < 3; mode++)
      for (int n = 1; n <= 6; n++)
        run_frag(24'(n * 4099 + mode * 77), 12'(n * 311), 12'(mode * 1234 + n),
                 4'(n + mode), 8'(n * 37 + mode), n, mode, (n % 2) == 0);
    run_frag(24'hFFFFFF, 12'hFFF, 12'hFFF, 4'hF, 8'hFF, 3, 1, 1'b1);
    run_frag(24'h000000, 12'h000, 12'h000, 4'h0, 8'h00, 1, 2, 1'b0);
    check(exp_q.size() == 0, "R3 all words delivered", 64'(exp_q.size()), 64'h0);
    finish_run();
  end
endmodule